// File: doc/BRIEF.md
# Single-Clock JTAG Test Port Front End

This block lets a JTAG test access port run entirely inside one system clock domain, on the rising edge of `clk` only. The external test clock is treated as plain asynchronous data. A short chain of flip-flops samples it, and an edge detector turns each of its transitions into an enable that lasts exactly one `clk` cycle. The sampled clock is also driven back out as a returned clock. A probe that waits for the returned clock to follow each transition it makes cannot outrun the synchronizer, so no test-clock event is lost.

The rising enable steps a full sixteen-state TAP controller and shifts the scan registers. The falling enable loads the output data register. There are two data registers behind the controller: a one-bit bypass path and a read-only identification register. The instruction register selects between them. The active-low test reset clears the synchronizer, the controller and the instruction without waiting for a clock.

Top module: `tap_sync_front`

## Requirements
- R1: `jt_clk_ret` equals the value of `jt_clk` sampled at the `clk` rising edge SYNC_STAGES edges earlier (default 2), and is 0 while `jt_rst_n` is low.
- R2: While `jt_rst_n` is low, and at once (without a `clk` edge), `jt_clk_ret` is 0, `jt_dout_en` is 0 and `jt_dout` is at the idle level. The controller is put in Test-Logic-Reset and the identification instruction is selected.
- R3: Each returned-clock rising transition advances the controller and shifts the selected register by exactly one step. Each falling transition reloads `jt_dout` exactly once. In bypass this shows as a delay of exactly one test-clock cycle from `jt_din` to `jt_dout`.
- R4: `jt_mode` is sampled only on returned-clock rising transitions, and the controller follows the standard sixteen-state graph, including the pause and exit states. Five cycles with `jt_mode` high reach Test-Logic-Reset from any state, and that state re-selects the identification instruction.
- R5: `jt_dout` and `jt_dout_en` change only after a returned-clock falling transition. They are unchanged across every rising transition.
- R6: `jt_dout_en` is 1 exactly while the controller is in Shift-DR or Shift-IR. Otherwise `jt_dout` is driven to IDLE_LVL (default 1).
- R7: With the identification instruction active, Capture-DR loads ID_VALUE (default 32'h5E3C_71A5). Shift-DR presents it on `jt_dout` least significant bit first.
- R8: Capture-IR loads the value 1 (bit 0 set, all other bits 0) into the instruction shifter. Bits enter from `jt_din` at the most significant end and leave at bit 0. The shifted value takes effect on the falling transition in Update-IR.
- R9: Opcode IDCODE_OP (default 4'b0010) selects the identification register. Every other opcode selects the one-bit bypass register, which captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every flip-flop uses its rising edge |
| jt_rst_n | input | 1 | Asynchronous active-low test reset |
| jt_clk | input | 1 | Asynchronous test clock from the probe |
| jt_mode | input | 1 | Test mode select |
| jt_din | input | 1 | Serial test data in |
| jt_clk_ret | output | 1 | Re-timed test clock returned to the probe |
| jt_dout | output | 1 | Serial test data out, registered |
| jt_dout_en | output | 1 | High while `jt_dout` carries shift data |

## Verification
A controller that has lost its place in the state graph shows at the ports on the next falling transition. Either `jt_dout_en` rises or drops at the wrong test-clock cycle, or the identification or captured-instruction pattern comes out shifted by one bit. A fault in the synchronizer shows within SYNC_STAGES `clk` cycles, because the returned clock no longer lags the test clock by the set amount. A doubled or missing enable shows within one test-clock cycle as a wrong bypass delay. A wrong instruction decode shows on the first bit shifted after Update-IR.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_t;

  function automatic tap_st_t tap_next(input tap_st_t s, input logic m);
    tap_st_t n;
    unique case (s)
      TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
      default:   n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tsf_tck_sync.sv
module tsf_tck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_a,
  output logic tck_s,
  output logic rise_en,
  output logic fall_en
);
  logic last_q;

  generate
    if (STAGES == 1) begin : g_one
      logic stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= tck_a;
      end
      assign tck_s = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], tck_a};
      end
      assign tck_s = stg_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= tck_s;
  end

  assign rise_en = tck_s & ~last_q;
  assign fall_en = ~tck_s & last_q;

  // R3
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en |=> !rise_en);
  // R3
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_en |=> !fall_en);
  // R3
  enables_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_en && fall_en));

endmodule

// File: rtl/tsf_tap_fsm.sv
module tsf_tap_fsm
  import tsf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    mode,
  output tap_st_t state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= TS_RESET;
    else if (step) state <= tap_next(state, mode);
  end

  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step) |-> $stable(state));
  // R4
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_RESET && step && mode) |=> state == TS_RESET);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_IDLE && step && !mode) |=> state == TS_IDLE);

endmodule

// File: rtl/tsf_scan_regs.sv
module tsf_scan_regs
  import tsf_pkg::*;
#(
  parameter int                 IR_LEN    = 4,
  parameter int                 ID_LEN    = 32,
  parameter logic [ID_LEN-1:0]  ID_VALUE  = 32'h5E3C_71A5,
  parameter logic [IR_LEN-1:0]  IDCODE_OP = 4'b0010,
  parameter logic               IDLE_LVL  = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rise_en,
  input  logic    fall_en,
  input  tap_st_t state,
  input  logic    din,
  output logic    dout,
  output logic    dout_en
);
  localparam logic [IR_LEN-1:0] IR_CAPT = IR_LEN'(1);

  logic [IR_LEN-1:0] ir_sh;
  logic [IR_LEN-1:0] ir_cur;
  logic [ID_LEN-1:0] id_sh;
  logic              byp_q;
  logic              sel_id;

  assign sel_id = (ir_cur == IDCODE_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= IR_CAPT;
      id_sh <= '0;
      byp_q <= 1'b0;
    end else if (rise_en) begin
      case (state)
        TS_CAP_IR: ir_sh <= IR_CAPT;
        TS_SH_IR:  ir_sh <= {din, ir_sh[IR_LEN-1:1]};
        TS_CAP_DR: if (sel_id) id_sh <= ID_VALUE; else byp_q <= 1'b0;
        TS_SH_DR:  if (sel_id) id_sh <= {din, id_sh[ID_LEN-1:1]}; else byp_q <= din;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ir_cur <= IDCODE_OP;
    else if (state == TS_RESET)             ir_cur <= IDCODE_OP;
    else if (fall_en && state == TS_UPD_IR) ir_cur <= ir_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= IDLE_LVL;
      dout_en <= 1'b0;
    end else if (fall_en) begin
      if (state == TS_SH_IR) begin
        dout    <= ir_sh[0];
        dout_en <= 1'b1;
      end else if (state == TS_SH_DR) begin
        dout    <= sel_id ? id_sh[0] : byp_q;
        dout_en <= 1'b1;
      end else begin
        dout    <= IDLE_LVL;
        dout_en <= 1'b0;
      end
    end
  end

  // R5
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall_en) |-> ($stable(dout) && $stable(dout_en)));
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == IDLE_LVL);
  // R8
  ir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_en) && $past(state) != TS_RESET && state != TS_RESET) |-> $stable(ir_cur));

endmodule

// File: rtl/tap_sync_front.sv
module tap_sync_front #(
  parameter int              SYNC_STAGES = 2,
  parameter int              IR_LEN      = 4,
  parameter int              ID_LEN      = 32,
  parameter logic [31:0]     ID_VALUE    = 32'h5E3C_71A5,
  parameter logic [3:0]      IDCODE_OP   = 4'b0010,
  parameter logic            IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic jt_rst_n,
  input  logic jt_clk,
  input  logic jt_mode,
  input  logic jt_din,
  output logic jt_clk_ret,
  output logic jt_dout,
  output logic jt_dout_en
);
  import tsf_pkg::*;

  logic    tck_s;
  logic    rise_en;
  logic    fall_en;
  tap_st_t state;

  tsf_tck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (jt_rst_n),
    .tck_a   (jt_clk),
    .tck_s   (tck_s),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  assign jt_clk_ret = tck_s;

  tsf_tap_fsm u_fsm (
    .clk   (clk),
    .rst_n (jt_rst_n),
    .step  (rise_en),
    .mode  (jt_mode),
    .state (state)
  );

  tsf_scan_regs #(
    .IR_LEN    (IR_LEN),
    .ID_LEN    (ID_LEN),
    .ID_VALUE  (ID_VALUE[ID_LEN-1:0]),
    .IDCODE_OP (IDCODE_OP[IR_LEN-1:0]),
    .IDLE_LVL  (IDLE_LVL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (jt_rst_n),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .state   (state),
    .din     (jt_din),
    .dout    (jt_dout),
    .dout_en (jt_dout_en)
  );

  // R6
  shift_only_chk: assert property (@(posedge clk) disable iff (!jt_rst_n)
    ($rose(jt_dout_en)) |-> (state == TS_SH_DR || state == TS_SH_IR));

endmodule

// File: tb/tap_sync_front_bench.sv
module tap_sync_front_bench;
  localparam int          SYNC = 2;
  localparam int          IRL  = 4;
  localparam logic [31:0] IDV  = 32'h5E3C_71A5;
  localparam logic [3:0]  IDOP = 4'b0010;

  localparam int M_RESET = 0, M_IDLE = 1, M_SDRS = 2, M_CDR = 3, M_SDR = 4,
                 M_E1D = 5, M_PDR = 6, M_E2D = 7, M_UDR = 8, M_SIRS = 9,
                 M_CIR = 10, M_SIR = 11, M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

  logic clk = 0;
  logic jt_rst_n = 0, jt_clk = 0, jt_mode = 1, jt_din = 0;
  logic jt_clk_ret, jt_dout, jt_dout_en;

  int checks = 0, errors = 0;
  int st = M_RESET;
  logic [3:0] irv = IDOP;
  bit ir_q[$];
  bit dr_q[$];
  bit hist[$];
  logic exp_dout = 1, exp_en = 0;

  always #10 clk = ~clk;

  tap_sync_front #(.SYNC_STAGES(SYNC)) u_tap_sync_front (
    .clk(clk), .jt_rst_n(jt_rst_n), .jt_clk(jt_clk), .jt_mode(jt_mode),
    .jt_din(jt_din), .jt_clk_ret(jt_clk_ret), .jt_dout(jt_dout), .jt_dout_en(jt_dout_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // R1: returned clock compared every clock against a delay queue
  initial for (int i = 0; i < SYNC; i++) hist.push_back(1'b0);
  always @(posedge clk) begin
    if (!jt_rst_n) begin
      foreach (hist[i]) hist[i] = 1'b0;
    end else begin
      hist.push_front(jt_clk);
      void'(hist.pop_back());
    end
    #5;
    chk("R1 returned clock", jt_clk_ret, jt_rst_n ? hist[SYNC-1] : 1'b0);
  end

  function automatic int mnext(input int s, input bit m);
    case (s)
      M_RESET: return m ? M_RESET : M_IDLE;
      M_IDLE:  return m ? M_SDRS : M_IDLE;
      M_SDRS:  return m ? M_SIRS : M_CDR;
      M_CDR:   return m ? M_E1D : M_SDR;
      M_SDR:   return m ? M_E1D : M_SDR;
      M_E1D:   return m ? M_UDR : M_PDR;
      M_PDR:   return m ? M_E2D : M_PDR;
      M_E2D:   return m ? M_UDR : M_SDR;
      M_UDR:   return m ? M_SDRS : M_IDLE;
      M_SIRS:  return m ? M_RESET : M_CIR;
      M_CIR:   return m ? M_E1I : M_SIR;
      M_SIR:   return m ? M_E1I : M_SIR;
      M_E1I:   return m ? M_UIR : M_PIR;
      M_PIR:   return m ? M_E2I : M_PIR;
      M_E2I:   return m ? M_UIR : M_SIR;
      default: return m ? M_SDRS : M_IDLE;
    endcase
  endfunction

  // probe half period: drive, then wait for the returned clock to follow
  task automatic half(input logic v);
    @(negedge clk) jt_clk = v;
    while (jt_clk_ret !== v) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic m, input logic d, input string tag);
    @(negedge clk); jt_mode = m; jt_din = d;
    // model, rising transition
    case (st)
      M_CIR: begin ir_q.delete(); for (int i = 0; i < IRL; i++) ir_q.push_back(i == 0); end
      M_SIR: begin void'(ir_q.pop_front()); ir_q.push_back(d); end
      M_CDR: begin
        dr_q.delete();
        if (irv == IDOP) for (int i = 0; i < 32; i++) dr_q.push_back(IDV[i]);
        else dr_q.push_back(1'b0);
      end
      M_SDR: begin void'(dr_q.pop_front()); dr_q.push_back(d); end
      default: ;
    endcase
    st = mnext(st, m);
    if (st == M_RESET) irv = IDOP;
    half(1'b1);
    chk("R5 dout held over rise", jt_dout, exp_dout);
    chk("R5 dout_en held over rise", jt_dout_en, exp_en);
    // model, falling transition
    if (st == M_UIR) for (int i = 0; i < IRL; i++) irv[i] = ir_q[i];
    if (st == M_SIR)      begin exp_dout = ir_q[0]; exp_en = 1; end
    else if (st == M_SDR) begin exp_dout = dr_q[0]; exp_en = 1; end
    else                  begin exp_dout = 1;       exp_en = 0; end
    half(1'b0);
    chk("R6 dout_en", jt_dout_en, exp_en);
    chk(tag, jt_dout, exp_dout);
  endtask

  task automatic tlr(input string tag);
    for (int i = 0; i < 5; i++) step(1, 0, tag);
    step(0, 0, tag);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] bits, input string tag);
    step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
    for (int i = 0; i < n; i++) step(i == n - 1, bits[i], tag);
    step(1, 0, tag); step(0, 0, tag);
  endtask

  task automatic scan_ir(input logic [3:0] op, input string tag);
    step(1, 0, tag); step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
    for (int i = 0; i < IRL; i++) step(i == IRL - 1, op[i], tag);
    step(1, 0, tag); step(0, 0, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset values
    chk("R2 ret in reset", jt_clk_ret, 1'b0);
    chk("R2 dout in reset", jt_dout, 1'b1);
    chk("R2 dout_en in reset", jt_dout_en, 1'b0);
    jt_rst_n = 1;
    repeat (2) @(negedge clk);

    tlr("R4 reach reset");
    scan_dr(32, 32'h0, "R7 id bits");
    scan_ir(4'b1111, "R8 captured ir");
    scan_dr(12, 32'hB5D, "R9 R3 bypass");
    scan_ir(4'b0101, "R8 captured ir");
    scan_dr(10, 32'h2C6, "R9 bypass other opcode");
    scan_ir(IDOP, "R8 captured ir");
    scan_dr(32, 32'hFFFF_0000, "R7 id after select");
    scan_ir(4'b1111, "R8 captured ir");
    tlr("R4 five ones");
    scan_dr(32, 32'h0, "R4 id after reset");

    // R4: pause and exit states during a data scan
    scan_ir(4'b1111, "R8 captured ir");
    step(1, 0, "R4 pause"); step(0, 0, "R4 pause"); step(0, 0, "R4 pause");
    step(0, 1, "R4 pause"); step(1, 0, "R4 pause"); step(0, 0, "R4 pause");
    step(0, 0, "R4 pause"); step(1, 0, "R4 pause"); step(0, 1, "R4 pause");
    step(0, 0, "R4 pause"); step(1, 1, "R4 pause"); step(1, 0, "R4 pause");
    step(0, 0, "R4 pause");

    // R2: asynchronous reset in the middle of a bypass shift
    step(1, 0, "R2 pre"); step(0, 0, "R2 pre"); step(0, 0, "R2 pre");
    step(0, 1, "R2 pre"); step(0, 1, "R2 pre");
    @(negedge clk); jt_rst_n = 0; jt_clk = 0; #1;
    chk("R2 async ret", jt_clk_ret, 1'b0);
    chk("R2 async dout_en", jt_dout_en, 1'b0);
    chk("R2 async dout", jt_dout, 1'b1);
    st = M_RESET; irv = IDOP; exp_dout = 1; exp_en = 0;
    repeat (4) @(negedge clk);
    jt_rst_n = 1;
    repeat (2) @(negedge clk);
    step(0, 0, "R2 after reset");
    scan_dr(32, 32'h0, "R2 id after async reset");

    finish_run();
  end
endmodule